// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers 28 interrupt requests and presents to the processor core one 3-bit priority level: the highest level among the sources that are pending and enabled. Six of the requests come from external pins. The other twenty-two come from on-chip units: four timer channels, eight USB endpoints, two UARTs, two line-interface sources, DMA, three Ethernet sources, a queued SPI and a watchdog timeout. Software gives each source a level from 0 to 7, where level 0 disables the source. When several pending sources share a level, a fixed source order picks the winner.

Software reaches the block through a single write port. This port sets the per-source levels, clears the sticky pending bits of the external pins, sets the vector base, sets the wakeup-enable mask and sets the power-down enable. The core runs an acknowledge cycle that names a level. The block answers one cycle later with the vector base plus the index of the winning source at that level. If no source qualifies, it answers with a spurious vector. No level and no real vector reach the core until software has written the vector base at least once after reset. Stack memory behind a chip select may not be ready before that point. The wakeup output does not depend on that gate.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source index i (0 to 27) has its level in bits [2:0] of a write to address i. Indices 0 to 5 are external pins 1 to 6 (port bits ext_irq_i[0..5]). Indices 6 to 27 are int_irq_i[0..21]. Index 6 is timer 0, and index 27 (int_irq_i[21]) is the watchdog timeout.
- R2: ipl_o equals the largest level among pending sources whose level is not zero. ipl_o is 0 when no such source exists. A level of 0 masks its source.
- R3: Among pending sources that share the acknowledged level, the source with the lowest index wins the vector.
- R4: Until the first write to the vector base (address 28, bits [7:0]), ipl_o stays 0 and every acknowledge returns the spurious vector.
- R5: An external pin passes through a two-flop synchronizer. A rising edge sets a sticky pending bit, which shows on pending_o at the third rising clock edge after the pin rises. The bit stays set after the pin falls.
- R6: A write to address i (i < 6) with bit 3 set clears external pending bit i. With bit 3 clear, the pending bit is unchanged. Bit 3 has no effect on internal sources. If a new rising edge arrives in the same cycle as the clear, the bit stays set.
- R7: The pending bit of an internal source follows its input in the same cycle, with no latching.
- R8: An acknowledge (iack_i with level iack_lvl_i) makes vec_vld_o high for exactly the following cycle. In that cycle vec_o is base plus the winning index (modulo 256), or SPUR_VEC (default 8'h18) if no pending source has a level equal to the nonzero requested level.
- R9: wake_o is high whenever power-down is enabled (address 30, bit 0) and some pending source has its bit set in the wakeup mask (address 29, bits [27:0]). This holds whether or not the base has been written.
- R10: After reset, all levels, pending bits, masks, the base and the power-down enable are zero, and the block is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_i | input | 6 | External interrupt pins, index 0 is highest priority |
| int_irq_i | input | 22 | Level-sensitive on-chip requests, bit 21 is the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 28 | Register write data |
| iack_i | input | 1 | Acknowledge request from the core |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Highest active priority level to the core |
| vec_vld_o | output | 1 | Vector answer valid |
| vec_o | output | 8 | Vector answer |
| pending_o | output | 28 | Pending bit for each source |
| wake_o | output | 1 | Wakeup request |

## Verification
The results arrive at different times, and the bench checks each one in the cycle it is due. ipl_o, wake_o and the internal pending bits are combinational from register state and inputs, so they are due in the same cycle as the stimulus. The register writes that change them take effect on the edge that samples the write. An external pin edge reaches pending_o after three clock edges, and an acknowledge answer is due one cycle after iack_i. The bench drives inputs just after a rising edge and compares every output against a behavioural model at each falling edge, so every delay is checked exactly and not through a loose wait.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int LVL_W = 3;
    localparam int IDX_W = 8;
    localparam int VEC_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    // per-source control word: pending-clear flag above the level field
    typedef struct packed {
        logic clr;
        lvl_t lvl;
    } ctl_word_t;

    // arbitration result at one requested level
    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [2:0] {
        RK_CTL,
        RK_BASE,
        RK_WAKE,
        RK_PDN,
        RK_NONE
    } reg_kind_e;

    function automatic reg_kind_e kind_of(input int unsigned addr, input int unsigned nsrc);
        if (addr < nsrc)           return RK_CTL;
        else if (addr == nsrc)     return RK_BASE;
        else if (addr == nsrc + 1) return RK_WAKE;
        else if (addr == nsrc + 2) return RK_PDN;
        else                       return RK_NONE;
    endfunction

endpackage

// File: rtl/prio_irq_ext_sync.sv
module prio_irq_ext_sync #(
    parameter int NEXT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_i,
    input  logic [NEXT-1:0] clr_i,
    output logic [NEXT-1:0] pend_o
);

    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_line
            logic [2:0] sh_q;   // [0],[1] synchronizer, [2] edge history
            logic       pend_q;
            logic       rise;

            assign rise = sh_q[1] & ~sh_q[2];

            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q   <= '0;
                    pend_q <= 1'b0;
                end else begin
                    sh_q   <= {sh_q[1:0], ext_i[g]};
                    pend_q <= (pend_q & ~clr_i[g]) | rise;
                end
            end

            assign pend_o[g] = pend_q;
        end
    endgenerate

endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 28,
    parameter int NEXT = 6,
    parameter int AW   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [NSRC-1:0]      wr_data_i,
    output lvl_t [NSRC-1:0]      lvl_o,
    output logic [NEXT-1:0]      clr_o,
    output vec_t                 base_o,
    output logic                 armed_o,
    output logic [NSRC-1:0]      wake_mask_o,
    output logic                 pdn_o
);

    ctl_word_t ctl;
    reg_kind_e kind;

    assign ctl  = ctl_word_t'(wr_data_i[LVL_W:0]);
    assign kind = kind_of(int'(wr_addr_i), NSRC);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_lvl
            lvl_t lvl_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q <= '0;
                end else if (wr_en_i && kind == RK_CTL && wr_addr_i == AW'(g)) begin
                    lvl_q <= ctl.lvl;
                end
            end
            assign lvl_o[g] = lvl_q;
        end

        for (g = 0; g < NEXT; g++) begin : g_clr
            assign clr_o[g] = wr_en_i && (kind == RK_CTL) && (wr_addr_i == AW'(g)) && ctl.clr;
        end
    endgenerate

    vec_t            base_q;
    logic            armed_q;
    logic [NSRC-1:0] wmask_q;
    logic            pdn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            armed_q <= 1'b0;
            wmask_q <= '0;
            pdn_q   <= 1'b0;
        end else if (wr_en_i) begin
            unique case (kind)
                RK_BASE: begin
                    base_q  <= wr_data_i[VEC_W-1:0];
                    armed_q <= 1'b1;
                end
                RK_WAKE: wmask_q <= wr_data_i;
                RK_PDN:  pdn_q   <= wr_data_i[0];
                default: ;
            endcase
        end
    end

    assign base_o      = base_q;
    assign armed_o     = armed_q;
    assign wake_mask_o = wmask_q;
    assign pdn_o       = pdn_q;

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 28
) (
    input  logic [NSRC-1:0] pend_i,
    input  lvl_t [NSRC-1:0] lvl_i,
    input  lvl_t            req_lvl_i,
    output lvl_t            max_lvl_o,
    output pick_t           pick_o
);

    // highest level over pending sources; level 0 never raises it
    always_comb begin
        max_lvl_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (lvl_i[i] > max_lvl_o)) begin
                max_lvl_o = lvl_i[i];
            end
        end
    end

    // scan from the bottom so the lowest matching index is written last
    always_comb begin
        pick_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (lvl_i[i] != '0) && (lvl_i[i] == req_lvl_i)) begin
                pick_o.found = 1'b1;
                pick_o.idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int   NEXT     = 6,
    parameter int   NINT     = 22,
    parameter logic [7:0] SPUR_VEC = 8'h18,
    localparam int  NSRC     = NEXT + NINT,
    localparam int  AW       = $clog2(NSRC + 3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NEXT-1:0]  ext_irq_i,
    input  logic [NINT-1:0]  int_irq_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [NSRC-1:0]  wr_data_i,
    input  logic             iack_i,
    input  logic [2:0]       iack_lvl_i,
    output logic [2:0]       ipl_o,
    output logic             vec_vld_o,
    output logic [7:0]       vec_o,
    output logic [NSRC-1:0]  pending_o,
    output logic             wake_o
);

    lvl_t [NSRC-1:0] lvl;
    logic [NEXT-1:0] clr;
    vec_t            base;
    logic            armed;
    logic [NSRC-1:0] wmask;
    logic            pdn;
    logic [NEXT-1:0] ext_pend;
    logic [NSRC-1:0] pend;
    lvl_t            max_lvl;
    pick_t           pick;

    prio_irq_regs #(.NSRC(NSRC), .NEXT(NEXT), .AW(AW)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .lvl_o       (lvl),
        .clr_o       (clr),
        .base_o      (base),
        .armed_o     (armed),
        .wake_mask_o (wmask),
        .pdn_o       (pdn)
    );

    prio_irq_ext_sync #(.NEXT(NEXT)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .ext_i  (ext_irq_i),
        .clr_i  (clr),
        .pend_o (ext_pend)
    );

    assign pend = {int_irq_i, ext_pend};

    prio_irq_arb #(.NSRC(NSRC)) arb_i (
        .pend_i    (pend),
        .lvl_i     (lvl),
        .req_lvl_i (iack_lvl_i),
        .max_lvl_o (max_lvl),
        .pick_o    (pick)
    );

    logic vld_q;
    vec_t vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            vec_q <= '0;
        end else begin
            vld_q <= iack_i;
            if (iack_i) begin
                vec_q <= (armed && pick.found) ? base + vec_t'(pick.idx) : SPUR_VEC;
            end
        end
    end

    assign ipl_o     = armed ? max_lvl : '0;
    assign vec_vld_o = vld_q;
    assign vec_o     = vec_q;
    assign pending_o = pend;
    assign wake_o    = pdn && |(pend & wmask);

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int NEXT = 6,
    parameter int NSRC = 28,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en_i,
    input logic [AW-1:0]   wr_addr_i,
    input logic [NSRC-1:0] wr_data_i,
    input logic            iack_i,
    input logic [2:0]      ipl_o,
    input logic            vec_vld_o,
    input logic [NSRC-1:0] pending_o,
    input logic            wake_o
);

    logic seen_base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_base_q <= 1'b0;
        end else if (wr_en_i && (int'(wr_addr_i) == NSRC)) begin
            seen_base_q <= 1'b1;
        end
    end

    AST_SILENT_BEFORE_BASE: assert property (@(posedge clk) disable iff (rst)
        !seen_base_q |-> (ipl_o == 3'd0)); // R4

    AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pending_o == '0) |-> (ipl_o == 3'd0)); // R2

    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        iack_i |=> vec_vld_o); // R8

    AST_NO_UNASKED_VECTOR: assert property (@(posedge clk) disable iff (rst)
        !iack_i |=> !vec_vld_o); // R8

    AST_WAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (pending_o != '0)); // R9

    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_sticky
            AST_EXT_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
                (pending_o[g] && !(wr_en_i && wr_addr_i == AW'(g) && wr_data_i[3]))
                |=> pending_o[g]); // R5
        end
    endgenerate

endmodule

bind prio_irq_ctrl prio_irq_chk #(.NEXT(NEXT), .NSRC(NSRC), .AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .iack_i    (iack_i),
    .ipl_o     (ipl_o),
    .vec_vld_o (vec_vld_o),
    .pending_o (pending_o),
    .wake_o    (wake_o)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NEXT = 6;
    localparam int NINT = 22;
    localparam int NSRC = NEXT + NINT;
    localparam int AW   = 5;
    localparam logic [7:0] SPUR = 8'h18;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NEXT-1:0] ext_irq = '0;
    logic [NINT-1:0] int_irq = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [NSRC-1:0] wr_data = '0;
    logic            iack = 1'b0;
    logic [2:0]      iack_lvl = '0;
    logic [2:0]      ipl;
    logic            vec_vld;
    logic [7:0]      vec;
    logic [NSRC-1:0] pending;
    logic            wake;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .iack_i(iack), .iack_lvl_i(iack_lvl), .ipl_o(ipl), .vec_vld_o(vec_vld),
        .vec_o(vec), .pending_o(pending), .wake_o(wake)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NEXT-1:0] m_h1, m_h2, m_h3, m_ext;
    int              m_lvl [NSRC];
    int              m_base;
    bit              m_armed, m_pdn, m_vld;
    logic [NSRC-1:0] m_wmask;
    int              m_vec;

    function automatic logic [NSRC-1:0] m_pend();
        return {int_irq, m_ext};
    endfunction

    function automatic int m_ipl();
        int best = 0;
        logic [NSRC-1:0] p = m_pend();
        if (!m_armed) return 0;
        for (int i = 0; i < NSRC; i++) if (p[i] && m_lvl[i] > best) best = m_lvl[i];
        return best;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_h1 = '0; m_h2 = '0; m_h3 = '0; m_ext = '0;
            for (int i = 0; i < NSRC; i++) m_lvl[i] = 0;
            m_base = 0; m_armed = 0; m_pdn = 0; m_wmask = '0; m_vld = 0; m_vec = 0;
        end else begin
            logic [NSRC-1:0] p;
            logic [NEXT-1:0] rise, clr;
            p = m_pend();
            m_vld = iack;
            if (iack) begin
                m_vec = SPUR;
                if (m_armed && iack_lvl != 0) begin
                    for (int i = NSRC - 1; i >= 0; i--)
                        if (p[i] && m_lvl[i] == int'(iack_lvl)) m_vec = (m_base + i) % 256;
                end
            end
            rise = m_h2 & ~m_h3;
            clr  = '0;
            if (wr_en && int'(wr_addr) < NEXT && wr_data[3]) clr[wr_addr] = 1'b1;
            m_ext = (m_ext & ~clr) | rise;
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = ext_irq;
            if (wr_en) begin
                if (int'(wr_addr) < NSRC) m_lvl[wr_addr] = int'(wr_data[2:0]);
                else if (int'(wr_addr) == NSRC) begin m_base = int'(wr_data[7:0]); m_armed = 1; end
                else if (int'(wr_addr) == NSRC + 1) m_wmask = wr_data;
                else if (int'(wr_addr) == NSRC + 2) m_pdn = wr_data[0];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 ipl", int'(ipl), m_ipl());
            check("R5/R7 pending", int'(pending), int'(m_pend()));
            check("R9 wake", int'(wake), int'(m_pdn && |(m_pend() & m_wmask)));
            check("R8 vld", int'(vec_vld), int'(m_vld));
            if (m_vld) check("R8 vector", int'(vec), m_vec);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = NSRC'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ack(input int l);
        @(posedge clk); #1;
        iack = 1'b1; iack_lvl = 3'(l);
        @(posedge clk); #1;
        iack = 1'b0;
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        rst = 1'b1;
        cycles(3);
        @(negedge clk);
        // R10 reset state
        check("R10 ipl", int'(ipl), 0);
        check("R10 pending", int'(pending), 0);
        check("R10 wake", int'(wake), 0);
        check("R10 vld", int'(vec_vld), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // before arming: levels set, sources active, yet silent (R4)
        wr(0, 5);
        wr(6, 3);
        ext_irq[0] = 1'b1; int_irq[0] = 1'b1;
        cycles(5);
        @(negedge clk);
        check("R4 ipl before base", int'(ipl), 0);
        check("R5 ext pending latched", int'(pending[0]), 1);
        check("R7 internal pending", int'(pending[6]), 1);
        ack(5);
        check("R4 spurious before base", int'(vec), int'(SPUR));

        // arm
        wr(NSRC, 8'h40);
        @(negedge clk);
        check("R2 max level after arm", int'(ipl), 5);
        ack(5);
        check("R8 vector idx0", int'(vec), 8'h40);
        ext_irq[0] = 1'b0;
        cycles(4);
        check("R5 sticky after pin low", int'(pending[0]), 1);

        // tie at level 5 with external 3 (index 2)
        wr(2, 5);
        ext_irq[2] = 1'b1;
        cycles(4);
        ack(5);
        check("R3 lower index wins tie", int'(vec), 8'h40);

        // clear index 0 (bit 3) and no-clear write to index 2
        wr(0, 8'h0D);
        @(negedge clk);
        check("R6 clear drops pending", int'(pending[0]), 0);
        wr(2, 5);
        @(negedge clk);
        check("R6 no-clear write keeps pending", int'(pending[2]), 1);
        ack(5);
        check("R3 next in tie after clear", int'(vec), 8'h42);

        // level 0 masks index 2
        wr(2, 0);
        @(negedge clk);
        check("R2 level zero masks", int'(ipl), 3);
        ack(3);
        check("R8 vector idx6", int'(vec), 8'h46);

        // watchdog at index 27 (R1)
        wr(27, 7);
        int_irq[21] = 1'b1;
        @(negedge clk);
        check("R1 watchdog level", int'(ipl), 7);
        ack(7);
        check("R1 watchdog vector", int'(vec), 8'h5B);
        wr(26, 7);
        int_irq[20] = 1'b1;
        ack(7);
        check("R3 internal tie", int'(vec), 8'h5A);

        // wakeup (R9)
        wr(NSRC + 1, 1 << 27);
        wr(NSRC + 2, 1);
        @(negedge clk);
        check("R9 wake on masked source", int'(wake), 1);
        @(posedge clk); #1;
        int_irq[21] = 1'b0; int_irq[20] = 1'b0;
        @(negedge clk);
        check("R9 wake drops", int'(wake), 0);

        // clear bit on internal source has no effect (R6)
        wr(6, 8'h0B);
        @(negedge clk);
        check("R6 internal ignores clear", int'(pending[6]), 1);
        ack(4);
        check("R8 spurious at empty level", int'(vec), int'(SPUR));

        // pseudo-random traffic compared every cycle
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            lfsr = step(lfsr);
            if (lfsr[3:0] == 4'h0) ext_irq = lfsr[9:4];
            if (lfsr[7:5] == 3'd1) int_irq = NINT'(lfsr[31:10]);
            iack = lfsr[12] & lfsr[2];
            iack_lvl = lfsr[15:13];
            wr_en = (lfsr[18:16] == 3'd2);
            wr_addr = AW'(lfsr[22:19] % 4'd8);
            wr_data = NSRC'({lfsr[23], lfsr[26:24]});
        end
        @(posedge clk); #1;
        wr_en = 1'b0; iack = 1'b0;

        // second reset: wake works without arming (R9)
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        int_irq = '0; ext_irq = '0;
        wr(NSRC + 1, 1 << 6);
        wr(NSRC + 2, 1);
        int_irq[0] = 1'b1;
        @(negedge clk);
        check("R9 wake unarmed", int'(wake), 1);
        check("R4 ipl unarmed", int'(ipl), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule